// File: doc/BRIEF.md
# Timed Tone Generator with Envelope

This block turns decoded sound commands into a shaped square-wave audio sample stream for a small game console. A command arrives as an opcode plus three operand bytes and, for one opcode, a 16-bit register value. The command set covers a stop, three fixed-pitch tones (500 Hz, 1000 Hz and 1500 Hz), a tone whose pitch in hertz comes from the register value, and a load of the envelope, volume and waveform parameters.

Every play command carries a duration in milliseconds. A prescaler derived from the system clock rate produces a millisecond tick that counts the duration down. A phase accumulator generates the pitch, and an attack/decay/sustain/release envelope scaled by a volume sets the amplitude of each high half of the wave. When the duration runs out the envelope fades through its release phase; a stop command silences the output at once.

Top module: `tone_gen`

## Requirements
- R1: After reset `sounding` and `timing` are 0, `audio` is 0, and the parameters are attack 0, decay 0, sustain 15, release 0, volume 15, shape 0.
- R2: Opcode 0x0A plays 500 Hz, 0x0B plays 1000 Hz and 0x0C plays 1500 Hz on `wave`, within one cycle of wave per 10 ms window.
- R3: Opcode 0x0D plays a tone whose frequency in hertz is the value on `cmd_pitch`, within one cycle of wave per 10 ms window.
- R4: A play command (0x0A to 0x0D) with duration D = {cmd_b3, cmd_b2} ms, D nonzero, holds `timing` high from the clock edge that accepts it for exactly D * CLK_HZ/1000 cycles; the millisecond prescaler restarts at that edge.
- R5: A play command with a duration of zero is ignored: an idle generator stays idle and silent.
- R6: Opcode 0x09 clears `sounding`, `timing` and `audio` at the clock edge that accepts it, whatever the envelope phase.
- R7: A play command that arrives while a tone is sounding restarts the duration count (and the millisecond prescaler) and restarts the envelope from level 0 in the attack phase.
- R8: The 8-bit envelope level starts at 0; on each millisecond tick it rises by 16 minus the attack nibble until it saturates at 255, then falls by 16 minus the decay nibble until it reaches the sustain level (sustain nibble times 17) and holds; `audio` is (level * volume) >> 4 while `wave` is high and 0 while it is low.
- R9: When the duration expires the envelope enters release: `sounding` stays high after `timing` falls, the level falls by 16 minus the release nibble per tick, and `sounding` drops when the level reaches 0.
- R10: Opcode 0x0E loads the parameters: cmd_b1 bits 7:4 attack, 3:0 decay; cmd_b2 bits 7:4 sustain, 3:0 release; cmd_b3 bits 7:4 volume, 3:0 shape.
- R11: Shape 0 gives a 50% duty square on `wave`; any nonzero shape gives a 25% duty pulse at the same pitch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded sound command is present this cycle |
| cmd_op | input | 8 | Opcode of the sound command |
| cmd_b1 | input | 8 | First operand byte (attack/decay nibbles for parameter load) |
| cmd_b2 | input | 8 | Second operand byte (duration low byte, or sustain/release) |
| cmd_b3 | input | 8 | Third operand byte (duration high byte, or volume/shape) |
| cmd_pitch | input | 16 | Register value giving the frequency in Hz for opcode 0x0D |
| wave | output | 1 | Raw tone waveform from the phase accumulator |
| audio | output | LVL_W | Envelope- and volume-scaled sample |
| sounding | output | 1 | Envelope is in any phase other than idle |
| timing | output | 1 | Duration countdown is still running |

## Verification
Pitch is tried with each fixed preset and with two register-supplied frequencies, counting wave cycles over a fixed window, which separates a wrong preset increment from a wrong multiply path. Durations are probed one cycle before and after the expected expiry, alone and with a second play arriving mid-tone, which tells a countdown that restarts from one that only extends. Envelope shaping is checked through the peak and plateau amplitude under two attack rates, two volumes and a low sustain setting, while the release tail and stop distinguish a fade from an immediate cut. Duty is measured under both shape codes, and a zero-duration play checks that nothing starts.

// File: rtl/tone_pkg.sv
package tone_pkg;

    localparam logic [7:0] OP_STOP      = 8'h09;
    localparam logic [7:0] OP_TONE_LO   = 8'h0A;
    localparam logic [7:0] OP_TONE_MID  = 8'h0B;
    localparam logic [7:0] OP_TONE_HI   = 8'h0C;
    localparam logic [7:0] OP_TONE_REG  = 8'h0D;
    localparam logic [7:0] OP_SET_PARAM = 8'h0E;

    typedef enum logic [2:0] {
        ENV_IDLE,
        ENV_ATTACK,
        ENV_DECAY,
        ENV_SUSTAIN,
        ENV_RELEASE
    } env_state_t;

    typedef struct packed {
        logic [3:0] atk;
        logic [3:0] dcy;
        logic [3:0] sus;
        logic [3:0] rls;
        logic [3:0] vol;
        logic [3:0] shape;
    } snd_param_t;

    // accumulator increment for a frequency at a given clock rate
    function automatic logic [63:0] phase_step(input longint unsigned freq,
                                               input longint unsigned clk_hz,
                                               input int unsigned acc_w);
        return (64'(freq) << acc_w) / 64'(clk_hz);
    endfunction

endpackage

// File: rtl/tone_ms_tick.sv
module tone_ms_tick #(
    parameter int unsigned CYC_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = (cnt_q == LAST);
        if (restart || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/tone_phase.sv
module tone_phase #(
    parameter int unsigned ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] step_in,
    input  logic [3:0]       shape,
    output logic             wave
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] step;
    } phase_t;

    phase_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (load) begin
            ph_d.acc  = '0;
            ph_d.step = step_in;
        end else begin
            ph_d.acc  = ph_q.acc + ph_q.step;
        end
    end

    // shape 0: half-period high; otherwise top quarter of the phase only
    always_comb begin
        if (shape == 4'd0) begin
            wave = ph_q.acc[ACC_W-1];
        end else begin
            wave = ph_q.acc[ACC_W-1] & ph_q.acc[ACC_W-2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end
endmodule

// File: rtl/tone_env.sv
module tone_env
    import tone_pkg::*;
#(
    parameter int unsigned LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             kill,
    input  logic             fade,
    input  logic             tick,
    input  logic [3:0]       atk,
    input  logic [3:0]       dcy,
    input  logic [3:0]       sus,
    input  logic [3:0]       rls,
    output env_state_t       state,
    output logic [LVL_W-1:0] level
);
    localparam int unsigned SH        = LVL_W - 8;
    localparam int unsigned SUS_SCALE = ((1 << LVL_W) - 1) / 15;
    localparam logic [LVL_W-1:0] TOP  = {LVL_W{1'b1}};

    typedef struct packed {
        env_state_t       st;
        logic [LVL_W-1:0] lvl;
    } env_t;

    env_t env_d, env_q;

    function automatic logic [LVL_W-1:0] rate_of(input logic [3:0] n);
        return LVL_W'(5'd16 - {1'b0, n}) << SH;
    endfunction

    logic [LVL_W-1:0] r_atk, r_dcy, r_rls, sus_lvl;
    logic [LVL_W:0]   up_sum, dn_floor;

    always_comb begin
        r_atk    = rate_of(atk);
        r_dcy    = rate_of(dcy);
        r_rls    = rate_of(rls);
        sus_lvl  = LVL_W'(SUS_SCALE * 32'(sus));
        up_sum   = {1'b0, env_q.lvl} + {1'b0, r_atk};
        dn_floor = {1'b0, sus_lvl} + {1'b0, r_dcy};

        env_d = env_q;
        if (kill) begin
            env_d.st  = ENV_IDLE;
            env_d.lvl = '0;
        end else if (start) begin
            env_d.st  = ENV_ATTACK;
            env_d.lvl = '0;
        end else if (fade && env_q.st != ENV_IDLE) begin
            env_d.st  = ENV_RELEASE;
        end else if (tick) begin
            case (env_q.st)
                ENV_ATTACK: begin
                    if (up_sum >= {1'b0, TOP}) begin
                        env_d.lvl = TOP;
                        env_d.st  = ENV_DECAY;
                    end else begin
                        env_d.lvl = up_sum[LVL_W-1:0];
                    end
                end
                ENV_DECAY: begin
                    if ({1'b0, env_q.lvl} <= dn_floor) begin
                        env_d.lvl = sus_lvl;
                        env_d.st  = ENV_SUSTAIN;
                    end else begin
                        env_d.lvl = env_q.lvl - r_dcy;
                    end
                end
                ENV_RELEASE: begin
                    if (env_q.lvl <= r_rls) begin
                        env_d.lvl = '0;
                        env_d.st  = ENV_IDLE;
                    end else begin
                        env_d.lvl = env_q.lvl - r_rls;
                    end
                end
                default: begin
                    env_d = env_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            env_q <= '{st: ENV_IDLE, lvl: '0};
        end else begin
            env_q <= env_d;
        end
    end

    assign state = env_q.st;
    assign level = env_q.lvl;
endmodule

// File: rtl/tone_gen.sv
module tone_gen
    import tone_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125000000,
    parameter int unsigned ACC_W  = 24,
    parameter int unsigned LVL_W  = 8,
    parameter int unsigned FRAC   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_op,
    input  logic [7:0]       cmd_b1,
    input  logic [7:0]       cmd_b2,
    input  logic [7:0]       cmd_b3,
    input  logic [15:0]      cmd_pitch,
    output logic             wave,
    output logic [LVL_W-1:0] audio,
    output logic             sounding,
    output logic             timing
);
    localparam int unsigned CYC_PER_MS = CLK_HZ / 1000;
    localparam int unsigned DUR_W      = 16;
    localparam logic [ACC_W-1:0] STEP_LO  = ACC_W'(phase_step(500,  CLK_HZ, ACC_W));
    localparam logic [ACC_W-1:0] STEP_MID = ACC_W'(phase_step(1000, CLK_HZ, ACC_W));
    localparam logic [ACC_W-1:0] STEP_HI  = ACC_W'(phase_step(1500, CLK_HZ, ACC_W));
    localparam logic [63:0] PITCH_MULT = (64'd1 << (ACC_W + FRAC)) / 64'(CLK_HZ);
    localparam snd_param_t PRM_RESET = '{atk: 4'h0, dcy: 4'h0, sus: 4'hF,
                                         rls: 4'h0, vol: 4'hF, shape: 4'h0};

    typedef struct packed {
        logic [DUR_W-1:0] dur;
        snd_param_t       prm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             is_play, do_start, do_stop, do_param, expire, tick;
    logic [DUR_W-1:0] dur_cmd;
    logic [ACC_W-1:0] step_sel;
    logic [63:0]      pitch_prod;
    env_state_t       env_state;
    logic [LVL_W-1:0] env_level;
    logic [LVL_W+3:0] scaled;

    always_comb begin
        is_play  = cmd_valid && (cmd_op == OP_TONE_LO  || cmd_op == OP_TONE_MID ||
                                 cmd_op == OP_TONE_HI  || cmd_op == OP_TONE_REG);
        dur_cmd  = {cmd_b3, cmd_b2};
        do_start = is_play && (dur_cmd != '0);
        do_stop  = cmd_valid && (cmd_op == OP_STOP);
        do_param = cmd_valid && (cmd_op == OP_SET_PARAM);
        expire   = tick && (ctl_q.dur == DUR_W'(1)) && !do_start && !do_stop;
    end

    always_comb begin
        pitch_prod = 64'(cmd_pitch) * PITCH_MULT;
        case (cmd_op)
            OP_TONE_LO:  step_sel = STEP_LO;
            OP_TONE_MID: step_sel = STEP_MID;
            OP_TONE_HI:  step_sel = STEP_HI;
            default:     step_sel = pitch_prod[FRAC +: ACC_W];
        endcase
    end

    always_comb begin
        ctl_d = ctl_q;
        if (do_stop) begin
            ctl_d.dur = '0;
        end else if (do_start) begin
            ctl_d.dur = dur_cmd;
        end else if (tick && ctl_q.dur != '0) begin
            ctl_d.dur = ctl_q.dur - 1'b1;
        end
        if (do_param) begin
            ctl_d.prm = snd_param_t'({cmd_b1, cmd_b2, cmd_b3});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{dur: '0, prm: PRM_RESET};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    tone_ms_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_start),
        .tick    (tick)
    );

    tone_phase #(.ACC_W(ACC_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (do_start),
        .step_in (step_sel),
        .shape   (ctl_q.prm.shape),
        .wave    (wave)
    );

    tone_env #(.LVL_W(LVL_W)) u_env (
        .clk   (clk),
        .rst_n (rst_n),
        .start (do_start),
        .kill  (do_stop),
        .fade  (expire),
        .tick  (tick),
        .atk   (ctl_q.prm.atk),
        .dcy   (ctl_q.prm.dcy),
        .sus   (ctl_q.prm.sus),
        .rls   (ctl_q.prm.rls),
        .state (env_state),
        .level (env_level)
    );

    always_comb begin
        scaled   = env_level * ctl_q.prm.vol;
        audio    = wave ? scaled[LVL_W+3:4] : '0;
        sounding = (env_state != ENV_IDLE);
        timing   = (ctl_q.dur != '0);
    end
endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
    parameter int unsigned LVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [7:0]       cmd_op,
    input logic [7:0]       cmd_b2,
    input logic [7:0]       cmd_b3,
    input logic             wave,
    input logic [LVL_W-1:0] audio,
    input logic             sounding,
    input logic             timing
);
    logic play_cmd;
    logic zero_dur;
    assign play_cmd = cmd_valid && (cmd_op >= 8'h0A) && (cmd_op <= 8'h0D);
    assign zero_dur = ({cmd_b3, cmd_b2} == 16'd0);

    a_r6_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 8'h09) |=> (!sounding && !timing && audio == '0));

    a_r1_idle_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !sounding |-> (audio == '0));

    a_r9_timing_needs_envelope: assert property (@(posedge clk) disable iff (!rst_n)
        timing |-> sounding);

    a_r5_zero_dur_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (play_cmd && zero_dur && !sounding) |=> !sounding);

    a_r7_play_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (play_cmd && !zero_dur) |=> (timing && sounding));

    a_r8_low_wave_mute: assert property (@(posedge clk) disable iff (!rst_n)
        !wave |-> (audio == '0));
endmodule

bind tone_gen tone_gen_chk #(.LVL_W(LVL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_b2    (cmd_b2),
    .cmd_b3    (cmd_b3),
    .wave      (wave),
    .audio     (audio),
    .sounding  (sounding),
    .timing    (timing)
);

// File: tb/sim_tone_gen.sv
`timescale 1ns/1ps
module sim_tone_gen;
    localparam int unsigned CLK_HZ = 100000;   // scaled: 100 cycles per ms
    localparam int MS = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_op = 8'h00, cmd_b1 = 8'h00, cmd_b2 = 8'h00, cmd_b3 = 8'h00;
    logic [15:0] cmd_pitch = 16'd0;
    logic        wave;
    logic [7:0]  audio;
    logic        sounding, timing;

    int total = 0;
    int bad = 0;
    int t_rel = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tone_gen #(.CLK_HZ(CLK_HZ), .ACC_W(24), .LVL_W(8), .FRAC(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_b1(cmd_b1), .cmd_b2(cmd_b2), .cmd_b3(cmd_b3), .cmd_pitch(cmd_pitch),
        .wave(wave), .audio(audio), .sounding(sounding), .timing(timing)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        total++;
        if (act < lo || act > hi) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    // command accepted at the next rising edge; returns half a cycle after it
    task automatic send(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2,
                        input logic [7:0] b3, input logic [15:0] pitch);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_b1 = b1; cmd_b2 = b2; cmd_b3 = b3; cmd_pitch = pitch;
        @(negedge clk);
        cmd_valid = 1'b0;
        t_rel = 0;
    endtask

    task automatic play(input logic [7:0] op, input int dur_ms, input logic [15:0] pitch);
        send(op, 8'h00, 8'(dur_ms), 8'(dur_ms >> 8), pitch);
    endtask

    task automatic wait_to(input int target);
        while (t_rel < target) begin
            @(negedge clk);
            t_rel++;
        end
    endtask

    task automatic measure(input int from, input int to, output int rises,
                           output int highs, output int peak);
        logic prev;
        rises = 0; highs = 0; peak = 0;
        wait_to(from);
        prev = wave;
        while (t_rel < to) begin
            @(negedge clk);
            t_rel++;
            if (wave && !prev) rises++;
            if (wave) highs++;
            if (int'(audio) > peak) peak = int'(audio);
            prev = wave;
        end
    endtask

    task automatic quiet();
        send(8'h09, 8'h00, 8'h00, 8'h00, 16'd0);
        wait_to(5);
    endtask

    task automatic t_reset();
        wait_to(3);
        chk("R1 sounding after reset", int'(sounding), 0);
        chk("R1 timing after reset", int'(timing), 0);
        chk("R1 audio after reset", int'(audio), 0);
    endtask

    task automatic t_presets();
        int r, h, p;
        play(8'h0A, 20, 16'd0);
        measure(2 * MS, 12 * MS, r, h, p);
        chk_rng("R2 500 Hz rises in 10 ms", r, 4, 6);
        play(8'h0B, 20, 16'd0);
        measure(2 * MS, 12 * MS, r, h, p);
        chk_rng("R2 1000 Hz rises in 10 ms", r, 9, 11);
        play(8'h0C, 20, 16'd0);
        measure(2 * MS, 12 * MS, r, h, p);
        chk_rng("R2 1500 Hz rises in 10 ms", r, 14, 16);
        quiet();
    endtask

    task automatic t_pitch();
        int r, h, p;
        play(8'h0D, 20, 16'd2300);
        measure(2 * MS, 12 * MS, r, h, p);
        chk_rng("R3 register pitch 2300 Hz", r, 22, 24);
        play(8'h0D, 20, 16'd700);
        measure(2 * MS, 12 * MS, r, h, p);
        chk_rng("R3 register pitch 700 Hz", r, 6, 8);
        quiet();
    endtask

    task automatic t_duration();
        play(8'h0C, 7, 16'd0);
        wait_to(7 * MS - 1);
        chk("R4 timing on last cycle of 7 ms", int'(timing), 1);
        wait_to(7 * MS);
        chk("R4 timing after 7 ms", int'(timing), 0);
        quiet();
    endtask

    task automatic t_zero_duration();
        int r, h, p;
        play(8'h0B, 0, 16'd0);
        wait_to(50);
        chk("R5 zero duration: sounding", int'(sounding), 0);
        chk("R5 zero duration: timing", int'(timing), 0);
        measure(50, 300, r, h, p);
        chk("R5 zero duration: audio peak", p, 0);
    endtask

    task automatic t_stop();
        int r, h, p;
        play(8'h0C, 40, 16'd0);
        wait_to(3 * MS);
        send(8'h09, 8'h00, 8'h00, 8'h00, 16'd0);
        chk("R6 stop: sounding", int'(sounding), 0);
        chk("R6 stop: timing", int'(timing), 0);
        measure(0, 2 * MS, r, h, p);
        chk("R6 stop: audio peak after stop", p, 0);
    endtask

    task automatic t_restart();
        play(8'h0B, 10, 16'd0);
        wait_to(6 * MS);
        play(8'h0B, 10, 16'd0);
        wait_to(4 * MS - 1);
        chk("R7 still timing past first expiry", int'(timing), 1);
        wait_to(10 * MS - 1);
        chk("R7 timing just before restarted expiry", int'(timing), 1);
        wait_to(10 * MS);
        chk("R7 timing after restarted expiry", int'(timing), 0);
        quiet();
    endtask

    task automatic t_envelope();
        int r, h, p;
        send(8'h0E, 8'h00, 8'h80, 8'hF0, 16'd0);
        play(8'h0B, 50, 16'd0);
        measure(16 * MS + 10, 16 * MS + 90, r, h, p);
        chk("R8 attack peak audio (255*15>>4)", p, 239);
        measure(40 * MS, 42 * MS, r, h, p);
        chk("R8 sustain audio (136*15>>4)", p, 127);
        quiet();
    endtask

    task automatic t_release();
        send(8'h0E, 8'h00, 8'h80, 8'hF0, 16'd0);
        play(8'h0B, 30, 16'd0);
        wait_to(30 * MS + 50);
        chk("R9 timing off after expiry", int'(timing), 0);
        chk("R9 sounding during release", int'(sounding), 1);
        wait_to(38 * MS + 50);
        chk("R9 sounding before release ends", int'(sounding), 1);
        wait_to(39 * MS + 50);
        chk("R9 sounding after release ends", int'(sounding), 0);
        quiet();
    endtask

    task automatic t_params();
        int r, h, p;
        send(8'h0E, 8'hF0, 8'hF0, 8'hF0, 16'd0);
        play(8'h0B, 30, 16'd0);
        measure(10 * MS + 10, 10 * MS + 90, r, h, p);
        chk("R10 slow attack level 10 (10*15>>4)", p, 9);
        quiet();
        send(8'h0E, 8'h00, 8'hF0, 8'h80, 16'd0);
        play(8'h0B, 30, 16'd0);
        measure(20 * MS, 22 * MS, r, h, p);
        chk("R10 volume 8 at level 255", p, 127);
        quiet();
    endtask

    task automatic t_shape();
        int r, h, p;
        send(8'h0E, 8'h00, 8'hF0, 8'hF1, 16'd0);
        play(8'h0B, 20, 16'd0);
        measure(5 * MS, 15 * MS, r, h, p);
        chk_rng("R11 shape 1 high cycles in 10 ms", h, 242, 258);
        send(8'h0E, 8'h00, 8'hF0, 8'hF0, 16'd0);
        play(8'h0B, 20, 16'd0);
        measure(5 * MS, 15 * MS, r, h, p);
        chk_rng("R11 shape 0 high cycles in 10 ms", h, 492, 508);
        quiet();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_rel = 0;
        t_reset();
        t_presets();
        t_pitch();
        t_duration();
        t_zero_duration();
        t_stop();
        t_restart();
        t_envelope();
        t_release();
        t_params();
        t_shape();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule